// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block sits beside the control unit of a small 8-bit processor and carries out the hardware side of taking an interrupt. The control unit pulses an instruction-boundary strobe each time an instruction retires. On that strobe the sequencer decides whether to enter a handler instead of fetching the next instruction.

A hardware entry needs the interrupt-enable bit of the status register set and at least one device request line active. A software interrupt opcode forces an entry whatever the enable bit says, and it supplies its own vector number. Once an entry is accepted, five bus phases follow. The first two phases move the stack pointer down and save the program counter. The third saves the status register. The last two load a new program counter and a new status register from a two-byte vector table. The sequencer reports each register update to the datapath through write strobes. It pulses `done` when the new handler context is in place.

The stack grows downward and all arithmetic on it wraps within 8 bits. Handlers normally load a status value with the enable bit clear, so a second entry cannot begin until the handler sets that bit again.

Top module: `irq_entry_seq`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the block is idle: busy, done, mem_we, mem_re, sp_we, pc_we and ps_we are all 0.
- R2: An entry is accepted only at a clock edge where insn_done is 1 and either swi_req is 1 or (ps_in bit 7, the enable bit, is 1 and irq_lines is non-zero). In every other idle case the block stays idle and drives no strobes.
- R3: For a hardware entry the vector number R is the lowest-numbered active bit of irq_lines. It is latched at the accepting edge, and later changes of irq_lines do not alter the sequence in progress.
- R4: Phase 1 (the first cycle after acceptance) asserts sp_we with sp_out = SP-1 and makes no memory access. SP, PC and PS denote the sp_in, pc_in and ps_in values at the accepting edge.
- R5: Phase 2 writes PC to address SP-1 (mem_we=1) and asserts sp_we with sp_out = SP-2.
- R6: Phase 3 writes PS to address SP-2 and leaves sp_we at 0.
- R7: Phase 4 reads address 0xF0 + 2*R (mem_re=1) and asserts pc_we with pc_out equal to the read data, which is valid in the same cycle.
- R8: Phase 5 reads address 0xF1 + 2*R and asserts ps_we with ps_out equal to the read data.
- R9: busy is 1 in phases 1 to 5 only. done is a single-cycle pulse in the cycle right after phase 5, and the block is idle in that cycle.
- R10: A software entry (swi_req=1 with insn_done=1) takes R from swi_num, ignores the enable bit, and takes precedence over any active irq_lines.
- R11: All stack addresses wrap modulo 256. With SP=0x01 the pushes land at 0x00 and 0xFF, and sp_out ends at 0xFF.
- R12: insn_done, swi_req and irq_lines have no effect while busy is 1. The five phases always run in order to completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_done | input | 1 | Instruction boundary strobe |
| irq_lines | input | 8 | Device request lines, bit n = device n |
| swi_req | input | 1 | Software interrupt opcode retiring with this boundary |
| swi_num | input | 3 | Vector number carried by the software interrupt |
| sp_in | input | 8 | Current stack pointer |
| pc_in | input | 8 | Address of the next instruction |
| ps_in | input | 8 | Current status register, bit 7 = interrupt enable |
| mem_rdata | input | 8 | Memory read data, combinational from mem_addr |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| sp_we | output | 1 | Stack pointer update strobe |
| sp_out | output | 8 | New stack pointer value |
| pc_we | output | 1 | Program counter update strobe |
| pc_out | output | 8 | New program counter value |
| ps_we | output | 1 | Status register update strobe |
| ps_out | output | 8 | New status register value |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | One-cycle pulse after the last phase |

## Verification
The properties assume that the datapath keeps sp_in, pc_in and ps_in steady during an entry, except through the sequencer's own strobes. In phase 1, sp_in therefore still equals the value captured at acceptance. They also assume that memory returns read data in the same cycle. The bench models this directly: its register file changes only on sp_we, pc_we and ps_we, its memory is an asynchronous array, and it sets register values only while the block is idle. Stimulus then deliberately toggles requests and boundary strobes in the middle of a sequence, which the block must ignore.

// File: rtl/irq_entry_pkg.sv
// Shared types for the interrupt entry sequencer.
// Assumes: the phase encoding is internal; no neighbour decodes it.
package irq_entry_pkg;
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_DEC     = 3'd1,
        PH_PUSH_PC = 3'd2,
        PH_PUSH_PS = 3'd3,
        PH_LD_PC   = 3'd4,
        PH_LD_PS   = 3'd5
    } phase_e;
endpackage

// File: rtl/irq_pick.sv
// Fixed-priority picker: reports whether any request line is active and
// the lowest-numbered active line. Purely combinational.
// Assumes: NUM_DEV >= 2.
module irq_pick #(
    parameter int NUM_DEV = 8,
    localparam int NUM_W  = $clog2(NUM_DEV)
) (
    input  logic [NUM_DEV-1:0] lines,
    output logic               any,
    output logic [NUM_W-1:0]   num
);
    // Any-request flag.
    assign any = |lines;

    // Scan from the top down so the lowest active index is written last.
    always_comb begin
        num = '0;
        for (int i = NUM_DEV - 1; i >= 0; i--) begin
            if (lines[i]) num = NUM_W'(i);
        end
    end
endmodule

// File: rtl/irq_entry_ctl.sv
// Phase controller: decides acceptance at an instruction boundary, takes a
// snapshot of SP/PC/PS and the vector number, then steps through the five
// entry phases and pulses done afterwards.
// Assumes: register inputs are valid at the boundary strobe.
module irq_entry_ctl
    import irq_entry_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int NUM_DEV = 8,
    parameter int IE_BIT  = 7,
    localparam int NUM_W  = $clog2(NUM_DEV)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_done,
    input  logic              swi_req,
    input  logic [NUM_W-1:0]  swi_num,
    input  logic              hw_any,
    input  logic [NUM_W-1:0]  hw_num,
    input  logic [DATA_W-1:0] sp_in,
    input  logic [DATA_W-1:0] pc_in,
    input  logic [DATA_W-1:0] ps_in,
    output phase_e            phase,
    output logic [NUM_W-1:0]  vec_num,
    output logic [DATA_W-1:0] sp_base,
    output logic [DATA_W-1:0] pc_save,
    output logic [DATA_W-1:0] ps_save,
    output logic              done
);
    logic   accept;
    phase_e phase_nx;

    // Acceptance: software entry always, hardware entry only when enabled.
    assign accept = (phase == PH_IDLE) && insn_done &&
                    (swi_req || (ps_in[IE_BIT] && hw_any));

    // Next-phase selection; each phase lasts exactly one cycle.
    always_comb begin
        unique case (phase)
            PH_IDLE:    phase_nx = accept ? PH_DEC : PH_IDLE;
            PH_DEC:     phase_nx = PH_PUSH_PC;
            PH_PUSH_PC: phase_nx = PH_PUSH_PS;
            PH_PUSH_PS: phase_nx = PH_LD_PC;
            PH_LD_PC:   phase_nx = PH_LD_PS;
            PH_LD_PS:   phase_nx = PH_IDLE;
            default:    phase_nx = PH_IDLE;
        endcase
    end

    // Phase register and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            done  <= 1'b0;
        end else begin
            phase <= phase_nx;
            done  <= (phase == PH_LD_PS);
        end
    end

    // Snapshot of the context and vector number, taken only on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_num <= '0;
            sp_base <= '0;
            pc_save <= '0;
            ps_save <= '0;
        end else if (accept) begin
            vec_num <= swi_req ? swi_num : hw_num;
            sp_base <= sp_in;
            pc_save <= pc_in;
            ps_save <= ps_in;
        end
    end
endmodule

// File: rtl/irq_entry_bus.sv
// Bus decoder: turns the current phase into memory and register strobes,
// addresses and data. Purely combinational.
// Assumes: memory read data is valid in the same cycle as the address.
module irq_entry_bus
    import irq_entry_pkg::*;
#(
    parameter int                DATA_W   = 8,
    parameter int                NUM_DEV  = 8,
    parameter logic [DATA_W-1:0] VEC_BASE = 8'hF0,
    localparam int               NUM_W    = $clog2(NUM_DEV)
) (
    input  phase_e            phase,
    input  logic [NUM_W-1:0]  vec_num,
    input  logic [DATA_W-1:0] sp_base,
    input  logic [DATA_W-1:0] pc_save,
    input  logic [DATA_W-1:0] ps_save,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic              sp_we,
    output logic [DATA_W-1:0] sp_out,
    output logic              pc_we,
    output logic [DATA_W-1:0] pc_out,
    output logic              ps_we,
    output logic [DATA_W-1:0] ps_out
);
    logic [DATA_W-1:0] sp_m1, sp_m2, vec_lo, vec_hi;

    // Wrapping stack slots and vector table addresses.
    assign sp_m1  = sp_base - DATA_W'(1);
    assign sp_m2  = sp_base - DATA_W'(2);
    assign vec_lo = VEC_BASE + (DATA_W'(vec_num) << 1);
    assign vec_hi = vec_lo + DATA_W'(1);

    // Per-phase strobe and data selection.
    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        sp_we     = 1'b0;
        sp_out    = '0;
        pc_we     = 1'b0;
        pc_out    = '0;
        ps_we     = 1'b0;
        ps_out    = '0;
        unique case (phase)
            PH_DEC: begin
                sp_we  = 1'b1;
                sp_out = sp_m1;
            end
            PH_PUSH_PC: begin
                mem_we    = 1'b1;
                mem_addr  = sp_m1;
                mem_wdata = pc_save;
                sp_we     = 1'b1;
                sp_out    = sp_m2;
            end
            PH_PUSH_PS: begin
                mem_we    = 1'b1;
                mem_addr  = sp_m2;
                mem_wdata = ps_save;
            end
            PH_LD_PC: begin
                mem_re   = 1'b1;
                mem_addr = vec_lo;
                pc_we    = 1'b1;
                pc_out   = mem_rdata;
            end
            PH_LD_PS: begin
                mem_re   = 1'b1;
                mem_addr = vec_hi;
                ps_we    = 1'b1;
                ps_out   = mem_rdata;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_entry_seq.sv
// Interrupt entry sequencer top: priority picker, phase controller and bus
// decoder. Runs the five-phase push/vector-load sequence after an accepted
// boundary.
// Assumes: the datapath applies sp/pc/ps strobes at the next clock edge.
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int                DATA_W   = 8,
    parameter int                NUM_DEV  = 8,
    parameter int                IE_BIT   = 7,
    parameter logic [DATA_W-1:0] VEC_BASE = 8'hF0,
    localparam int               NUM_W    = $clog2(NUM_DEV)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               insn_done,
    input  logic [NUM_DEV-1:0] irq_lines,
    input  logic               swi_req,
    input  logic [NUM_W-1:0]   swi_num,
    input  logic [DATA_W-1:0]  sp_in,
    input  logic [DATA_W-1:0]  pc_in,
    input  logic [DATA_W-1:0]  ps_in,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [DATA_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic               mem_we,
    output logic               mem_re,
    output logic               sp_we,
    output logic [DATA_W-1:0]  sp_out,
    output logic               pc_we,
    output logic [DATA_W-1:0]  pc_out,
    output logic               ps_we,
    output logic [DATA_W-1:0]  ps_out,
    output logic               busy,
    output logic               done
);
    logic              hw_any;
    logic [NUM_W-1:0]  hw_num, vec_num;
    logic [DATA_W-1:0] sp_base, pc_save, ps_save;
    phase_e            phase;

    irq_pick #(.NUM_DEV(NUM_DEV)) u_pick (
        .lines (irq_lines),
        .any   (hw_any),
        .num   (hw_num)
    );

    irq_entry_ctl #(.DATA_W(DATA_W), .NUM_DEV(NUM_DEV), .IE_BIT(IE_BIT)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .insn_done (insn_done),
        .swi_req   (swi_req),
        .swi_num   (swi_num),
        .hw_any    (hw_any),
        .hw_num    (hw_num),
        .sp_in     (sp_in),
        .pc_in     (pc_in),
        .ps_in     (ps_in),
        .phase     (phase),
        .vec_num   (vec_num),
        .sp_base   (sp_base),
        .pc_save   (pc_save),
        .ps_save   (ps_save),
        .done      (done)
    );

    irq_entry_bus #(.DATA_W(DATA_W), .NUM_DEV(NUM_DEV), .VEC_BASE(VEC_BASE)) u_bus (
        .phase     (phase),
        .vec_num   (vec_num),
        .sp_base   (sp_base),
        .pc_save   (pc_save),
        .ps_save   (ps_save),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .sp_we     (sp_we),
        .sp_out    (sp_out),
        .pc_we     (pc_we),
        .pc_out    (pc_out),
        .ps_we     (ps_we),
        .ps_out    (ps_out)
    );

    // Busy flag: any phase other than idle.
    assign busy = (phase != PH_IDLE);
endmodule

// File: rtl/irq_entry_chk.sv
// Property checker for irq_entry_seq, attached by bind below.
// Assumes: sp_in/pc_in/ps_in change only through the block's own strobes
// during an entry, and memory read data is same-cycle.
module irq_entry_chk #(
    parameter int DATA_W  = 8,
    parameter int NUM_DEV = 8,
    parameter int IE_BIT  = 7,
    localparam int NUM_W  = $clog2(NUM_DEV)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               insn_done,
    input logic [NUM_DEV-1:0] irq_lines,
    input logic               swi_req,
    input logic [DATA_W-1:0]  sp_in,
    input logic [DATA_W-1:0]  ps_in,
    input logic [DATA_W-1:0]  mem_addr,
    input logic               mem_we,
    input logic               mem_re,
    input logic               sp_we,
    input logic [DATA_W-1:0]  sp_out,
    input logic               pc_we,
    input logic               ps_we,
    input logic               busy,
    input logic               done
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_we || mem_re || sp_we || pc_we || ps_we));

    p_no_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(insn_done && (swi_req || (ps_in[IE_BIT] && |irq_lines)))) |=> !busy);

    p_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && insn_done && (swi_req || (ps_in[IE_BIT] && |irq_lines))) |=> (busy && sp_we && !mem_we));

    p_first_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_we && !mem_we) |-> (sp_out == DATA_W'(sp_in - DATA_W'(1))));

    p_push_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_we && !mem_we) |=> (mem_we && sp_we && mem_addr == $past(sp_out)));

    p_push_ps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && sp_we) |=> (mem_we && !sp_we && mem_addr == $past(sp_out)));

    p_vec_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |-> (mem_re && !mem_we && mem_addr[0] == 1'b0));

    p_vec_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |=> (ps_we && mem_re && mem_addr == DATA_W'($past(mem_addr) + DATA_W'(1))));

    p_done_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ps_we |=> (done && !busy));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_stay_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ps_we) |=> busy);

    p_one_access_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, mem_re}));
endmodule

bind irq_entry_seq irq_entry_chk #(
    .DATA_W(DATA_W), .NUM_DEV(NUM_DEV), .IE_BIT(IE_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .irq_lines(irq_lines),
    .swi_req(swi_req), .sp_in(sp_in), .ps_in(ps_in), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_re(mem_re), .sp_we(sp_we), .sp_out(sp_out),
    .pc_we(pc_we), .ps_we(ps_we), .busy(busy), .done(done)
);

// File: tb/sim_irq_entry_seq.sv
// Bench: behavioural reference model compared on every clock, plus
// end-of-sequence checks of stack contents and loaded registers.
module sim_irq_entry_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       insn_done = 1'b0;
    logic [7:0] irq_lines = '0;
    logic       swi_req = 1'b0;
    logic [2:0] swi_num = '0;
    logic [7:0] sp_r = 8'h80, pc_r = 8'h00, ps_r = 8'h00;
    logic [7:0] mem_rdata, mem_addr, mem_wdata, sp_out, pc_out, ps_out;
    logic       mem_we, mem_re, sp_we, pc_we, ps_we, busy, done;
    logic [7:0] mem [256];

    int checks = 0, failures = 0, cyc = 0, done_cnt = 0;

    // 200 MHz clock.
    always #2.5 clk = ~clk;

    assign mem_rdata = mem[mem_addr];

    irq_entry_seq u0 (
        .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .irq_lines(irq_lines),
        .swi_req(swi_req), .swi_num(swi_num), .sp_in(sp_r), .pc_in(pc_r),
        .ps_in(ps_r), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .sp_we(sp_we), .sp_out(sp_out), .pc_we(pc_we), .pc_out(pc_out),
        .ps_we(ps_we), .ps_out(ps_out), .busy(busy), .done(done)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    // Datapath registers and memory respond to the block's strobes.
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (sp_we) sp_r <= sp_out;
        if (pc_we) pc_r <= pc_out;
        if (ps_we) ps_r <= ps_out;
        if (done) done_cnt <= done_cnt + 1;
    end

    // Reference model state.
    int       m_ph = 0;
    logic     m_done = 1'b0;
    int       m_r = 0;
    bit [7:0] m_sp, m_pc, m_ps;

    function automatic int lowest(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) if (v[i]) lowest = i;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0;
            m_done = 1'b0;
        end else begin
            m_done = (m_ph == 5);
            if (m_ph == 0) begin
                if (insn_done && (swi_req || (ps_r[7] && irq_lines != 0))) begin
                    m_r  = swi_req ? int'(swi_num) : lowest(irq_lines);
                    m_sp = sp_r; m_pc = pc_r; m_ps = ps_r;
                    m_ph = 1;
                end
            end else begin
                m_ph = (m_ph == 5) ? 0 : m_ph + 1;
            end
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            bit [7:0] va;
            va = 8'hF0 + 8'(2 * m_r);
            chk("R9", "done", done, m_done);
            chk("R9", "busy", busy, m_ph != 0);
            case (m_ph)
                0: chk("R2", "idle strobes", {mem_we, mem_re, sp_we, pc_we, ps_we}, 0);
                1: begin
                    chk("R4", "strobes", {mem_we, mem_re, sp_we, pc_we, ps_we}, 5'b00100);
                    chk("R4", "sp_out", sp_out, 8'(m_sp - 8'd1));
                end
                2: begin
                    chk("R5", "strobes", {mem_we, mem_re, sp_we, pc_we, ps_we}, 5'b10100);
                    chk("R5", "addr", mem_addr, 8'(m_sp - 8'd1));
                    chk("R5", "wdata", mem_wdata, m_pc);
                    chk("R5", "sp_out", sp_out, 8'(m_sp - 8'd2));
                end
                3: begin
                    chk("R6", "strobes", {mem_we, mem_re, sp_we, pc_we, ps_we}, 5'b10000);
                    chk("R6", "addr", mem_addr, 8'(m_sp - 8'd2));
                    chk("R6", "wdata", mem_wdata, m_ps);
                end
                4: begin
                    chk("R7", "strobes", {mem_we, mem_re, sp_we, pc_we, ps_we}, 5'b01010);
                    chk("R7", "addr", mem_addr, va);
                    chk("R7", "pc_out", pc_out, mem[va]);
                end
                default: begin
                    chk("R8", "strobes", {mem_we, mem_re, sp_we, pc_we, ps_we}, 5'b01001);
                    chk("R8", "addr", mem_addr, 8'(va + 8'd1));
                    chk("R8", "ps_out", ps_out, mem[8'(va + 8'd1)]);
                end
            endcase
        end
    end

    task automatic boundary(input logic sw, input logic [2:0] sn, input logic [7:0] lines);
        @(negedge clk);
        insn_done = 1'b1; swi_req = sw; swi_num = sn; irq_lines = lines;
        @(negedge clk);
        insn_done = 1'b0; swi_req = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_ctx(input logic [7:0] sp, input logic [7:0] pc, input logic [7:0] ps);
        @(negedge clk);
        sp_r = sp; pc_r = pc; ps_r = ps;
    endtask

    // Full entry and end-of-sequence check of the stack and loaded registers.
    task automatic entry_check(input string tag, input logic sw, input logic [2:0] sn,
                               input logic [7:0] lines, input logic [7:0] sp,
                               input logic [7:0] pc, input logic [7:0] ps, input int r);
        int d0;
        set_ctx(sp, pc, ps);
        d0 = done_cnt;
        boundary(sw, sn, lines);
        idle_cycles(7);
        chk(tag, "stacked pc", mem[8'(sp - 8'd1)], pc);
        chk(tag, "stacked ps", mem[8'(sp - 8'd2)], ps);
        chk(tag, "final sp", sp_r, 8'(sp - 8'd2));
        chk(tag, "loaded pc", pc_r, mem[8'hF0 + 8'(2 * r)]);
        chk(tag, "loaded ps", ps_r, mem[8'hF1 + 8'(2 * r)]);
        chk("R9", "one done pulse", done_cnt - d0, 1);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            failures++;
            $display("FAIL watchdog: act=%0d exp=<20000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        for (int k = 0; k < 8; k++) begin
            mem[8'hF0 + 2 * k] = 8'h40 + 8'(16 * k);
            mem[8'hF1 + 2 * k] = 8'h05 + 8'(k);
        end
        idle_cycles(3);
        // R1: reset state.
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "strobes", {mem_we, mem_re, sp_we, pc_we, ps_we}, 0);
        @(negedge clk); rst_n = 1'b1;

        // R2: enable clear, request pending -> no entry.
        set_ctx(8'h80, 8'h33, 8'h00);
        boundary(1'b0, 3'd0, 8'h10);
        idle_cycles(7);
        chk("R2", "pc kept", pc_r, 8'h33);
        // R2: enable set, no request -> no entry.
        set_ctx(8'h80, 8'h33, 8'h80);
        boundary(1'b0, 3'd0, 8'h00);
        idle_cycles(7);
        chk("R2", "sp kept", sp_r, 8'h80);

        // R3 and R12: lines 2 and 4 -> device 2; disturb mid-sequence.
        set_ctx(8'h80, 8'h33, 8'h80);
        boundary(1'b0, 3'd0, 8'b0001_0100);
        @(negedge clk);
        irq_lines = 8'h01; insn_done = 1'b1; swi_req = 1'b1; swi_num = 3'd7;
        idle_cycles(2);
        insn_done = 1'b0; swi_req = 1'b0;
        idle_cycles(5);
        chk("R3", "vector pc dev2", pc_r, mem[8'hF4]);
        chk("R12", "stacked pc", mem[8'h7F], 8'h33);
        chk("R12", "stacked ps", mem[8'h7E], 8'h80);

        // R2: handler status has enable clear; pending line 0 is not taken.
        boundary(1'b0, 3'd0, 8'h01);
        idle_cycles(7);
        chk("R2", "no nested entry", pc_r, mem[8'hF4]);

        // R10: software entry with enable clear.
        entry_check("R10", 1'b1, 3'd5, 8'h00, 8'h60, 8'h21, 8'h00, 5);
        // R10: software entry beats hardware line 0.
        entry_check("R10", 1'b1, 3'd6, 8'h01, 8'h50, 8'h22, 8'h80, 6);
        // R3: single highest and lowest devices.
        entry_check("R3", 1'b0, 3'd0, 8'h80, 8'h40, 8'h23, 8'h80, 7);
        entry_check("R3", 1'b0, 3'd0, 8'hFF, 8'h30, 8'h24, 8'h81, 0);
        // R11: stack wrap.
        entry_check("R11", 1'b0, 3'd0, 8'h08, 8'h01, 8'h25, 8'h80, 3);
        chk("R11", "pc at 00", mem[8'h00], 8'h25);
        chk("R11", "ps at FF", mem[8'hFF], 8'h80);
        entry_check("R11", 1'b1, 3'd1, 8'h00, 8'h00, 8'h26, 8'h00, 1);

        idle_cycles(2);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule